// File: doc/BRIEF.md
# Two-Core Launch Control and Atomic Test-and-Set Unit

This block is the shared control logic that sits between the two cores of a dual-core machine and their common memory. It keeps one machine-wide mode bit, which is either *reset* (only the primary core runs) or *active* (both cores run). The primary core leaves reset mode with a launch command, which starts the secondary core at a fixed physical word address. Either core can put the machine back into reset mode with a stop command, and that stops the secondary core again.

The same unit serves all memory traffic from both cores through one shared memory port. A round-robin arbiter picks one request per cycle. Plain reads and writes take one memory cycle. An atomic test-and-set reads a word and then writes the value 1 to it in the next cycle. For that second cycle the bus stays locked, so the other core cannot reach memory between the read and the write. The launch command, the stop command and test-and-set are privileged: a core that issues one of them from user mode gets a fault response and changes nothing.

Each core holds its request (valid, opcode, address, write data, tag, kernel flag) until it sees its grant. Its response (valid, data, echoed tag, fault) comes exactly one cycle after the grant.

Top module: `dcore_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the unit is in reset mode. `sec_run` is 0, no grant is given, no response is valid and `mem_req` is 0.
- R2: A launch (opcode 3) from core 0 with `req_kernel`=1 in reset mode sets `sec_run` to 1 on the clock edge that grants it.
- R3: A launch issued while `sec_run` is 1 has no effect: `sec_run` stays 1 and the response carries fault 0.
- R4: A launch from core 1 has no effect in either mode: `sec_run` keeps its value and the response carries fault 0.
- R5: A stop (opcode 4) with `req_kernel`=1 from either core clears `sec_run` on the clock edge that grants it. A stop issued in reset mode has no effect.
- R6: Opcodes 2, 3 and 4 issued with `req_kernel`=0, and any opcode above 4, get a response with fault 1 and data 0. They change neither memory nor `sec_run`.
- R7: Test-and-set (opcode 2) returns the old value of the addressed word one cycle after the grant. In that same cycle the unit writes 1 to that word.
- R8: In the cycle after a privileged test-and-set is granted, neither core is granted, even if requests are pending.
- R9: At most one grant is given per cycle. A single requester is granted at once. When both cores request together, the core not granted most recently wins.
- R10: A read (opcode 0) returns the memory word, and a write (opcode 1) stores `req_wdata` and returns data 0. Every response is valid exactly one cycle after its grant, on the granted core only, and echoes that request's tag.
- R11: `sec_start_pc` equals START_PAGE × PAGE_WORDS, which is 65536 with the default parameters.

Memory model assumed: a write is committed at the clock edge where `mem_req`=`mem_we`=1. Read data is valid on `mem_rdata` in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 2 | Request pending, one bit per core (bit 0 = primary) |
| req_op | input | 2x3 | Opcode per core: 0 read, 1 write, 2 test-and-set, 3 launch, 4 stop |
| req_addr | input | 2xADDR_W | Word address per core |
| req_wdata | input | 2xDATA_W | Write data per core |
| req_tag | input | 2xTAG_W | Destination tag per core, echoed in the response |
| req_kernel | input | 2 | Core issues the request from privileged mode |
| grant | output | 2 | Request accepted this cycle |
| rsp_valid | output | 2 | Response for the core, one cycle after its grant |
| rsp_data | output | DATA_W | Response data |
| rsp_tag | output | TAG_W | Tag of the answered request |
| rsp_fault | output | 1 | Request was rejected |
| mem_req | output | 1 | Shared memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after the read |
| sec_run | output | 1 | Secondary core runs (machine in active mode) |
| sec_start_pc | output | ADDR_W | Physical address where the secondary core starts |

## Verification
A grant is combinational, so it is sampled in the same cycle the request is driven, a few nanoseconds after the falling edge. The response, the mode change on `sec_run` and the locked write of 1 are all due one rising edge later, and the bench samples them at the next falling edge. Read-back data that depends on an earlier write or test-and-set is requested only after that write's edge has passed. The lock test checks the grant vector in each of the three consecutive cycles of a colliding test-and-set and read.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_TSL   = 3'd2,
    OP_START = 3'd3,
    OP_STOP  = 3'd4
  } op_e;
  localparam int unsigned NCORE = 2;
endpackage

// File: rtl/dcc_rr_arb.sv
module dcc_rr_arb (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  input  logic       hold,
  output logic [1:0] gnt
);
  logic pref_q, pref_d, pref_en;

  always_comb begin
    gnt[0]  = !hold && req[0] && (!req[1] || !pref_q);
    gnt[1]  = !hold && req[1] && (!req[0] ||  pref_q);
    pref_en = |gnt;
    pref_d  = gnt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pref_q <= 1'b0;
    else if (pref_en) pref_q <= pref_d;
  end
endmodule

// File: rtl/dcc_mode.sv
module dcc_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_start,
  input  logic cmd_stop,
  output logic active
);
  logic active_q, active_d, active_en;

  always_comb begin
    active_en = cmd_start || cmd_stop;
    active_d  = active_q;
    if (!active_q && cmd_start)     active_d = 1'b1;
    else if (active_q && cmd_stop)  active_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         active_q <= 1'b0;
    else if (active_en) active_q <= active_d;
  end

  assign active = active_q;
endmodule

// File: rtl/dcc_mem_seq.sv
module dcc_mem_seq
  import dcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            gnt,
  input  logic [1:0][2:0]       req_op,
  input  logic [1:0][ADDR_W-1:0] req_addr,
  input  logic [1:0][DATA_W-1:0] req_wdata,
  input  logic [1:0][TAG_W-1:0] req_tag,
  input  logic [1:0]            req_kernel,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  lock,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [1:0]            rsp_valid,
  output logic [DATA_W-1:0]     rsp_data,
  output logic [TAG_W-1:0]      rsp_tag,
  output logic                  rsp_fault,
  output logic                  cmd_start,
  output logic                  cmd_stop
);
  logic              sel, any, priv_op, legal, fault, ok, acc, lock_d;
  logic [2:0]        op;
  logic              lock_q;
  logic [ADDR_W-1:0] lock_addr_q;
  logic [1:0]        rsp_v_q;
  logic [TAG_W-1:0]  rsp_tag_q;
  logic              rsp_fault_q, rsp_mem_q;

  always_comb begin
    sel       = gnt[1];
    any       = |gnt;
    op        = req_op[sel];
    priv_op   = (op == OP_TSL) || (op == OP_START) || (op == OP_STOP);
    legal     = (op <= OP_STOP);
    fault     = !legal || (priv_op && !req_kernel[sel]);
    ok        = any && !fault;
    acc       = ok && ((op == OP_READ) || (op == OP_WRITE) || (op == OP_TSL));
    lock_d    = ok && (op == OP_TSL);
    cmd_start = ok && (op == OP_START) && !sel;
    cmd_stop  = ok && (op == OP_STOP);
  end

  always_comb begin
    mem_req   = lock_q || acc;
    mem_we    = lock_q || (acc && (op == OP_WRITE));
    mem_addr  = lock_q ? lock_addr_q : req_addr[sel];
    mem_wdata = lock_q ? DATA_W'(1) : req_wdata[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      rsp_v_q <= 2'b00;
    end else begin
      lock_q  <= lock_d;
      rsp_v_q <= gnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lock_addr_q <= '0;
    else if (lock_d) lock_addr_q <= req_addr[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_tag_q   <= '0;
      rsp_fault_q <= 1'b0;
      rsp_mem_q   <= 1'b0;
    end else if (any) begin
      rsp_tag_q   <= req_tag[sel];
      rsp_fault_q <= fault;
      rsp_mem_q   <= acc && (op != OP_WRITE);
    end
  end

  assign lock      = lock_q;
  assign rsp_valid = rsp_v_q;
  assign rsp_tag   = rsp_tag_q;
  assign rsp_fault = (|rsp_v_q) && rsp_fault_q;
  assign rsp_data  = ((|rsp_v_q) && rsp_mem_q) ? mem_rdata : '0;
endmodule

// File: rtl/dcore_ctrl.sv
module dcore_ctrl #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned TAG_W      = 4,
  parameter int unsigned PAGE_WORDS = 512,
  parameter int unsigned START_PAGE = 128
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             req_valid,
  input  logic [1:0][2:0]        req_op,
  input  logic [1:0][ADDR_W-1:0] req_addr,
  input  logic [1:0][DATA_W-1:0] req_wdata,
  input  logic [1:0][TAG_W-1:0]  req_tag,
  input  logic [1:0]             req_kernel,
  output logic [1:0]             grant,
  output logic [1:0]             rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic [TAG_W-1:0]       rsp_tag,
  output logic                   rsp_fault,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [DATA_W-1:0]      mem_wdata,
  input  logic [DATA_W-1:0]      mem_rdata,
  output logic                   sec_run,
  output logic [ADDR_W-1:0]      sec_start_pc
);
  localparam logic [ADDR_W-1:0] START_PC = ADDR_W'(START_PAGE * PAGE_WORDS);

  logic lock, cmd_start, cmd_stop;

  dcc_rr_arb i_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (req_valid),
    .hold (lock),
    .gnt  (grant)
  );

  dcc_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .gnt       (grant),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_tag   (req_tag),
    .req_kernel(req_kernel),
    .mem_rdata (mem_rdata),
    .lock      (lock),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_tag   (rsp_tag),
    .rsp_fault (rsp_fault),
    .cmd_start (cmd_start),
    .cmd_stop  (cmd_stop)
  );

  dcc_mode i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_start(cmd_start),
    .cmd_stop (cmd_stop),
    .active   (sec_run)
  );

  assign sec_start_pc = START_PC;
endmodule

// File: rtl/dcc_checker.sv
module dcc_checker
  import dcc_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TAG_W  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0][2:0]        req_op,
  input logic [1:0]             req_kernel,
  input logic [1:0]             grant,
  input logic [1:0]             rsp_valid,
  input logic                   mem_req,
  input logic                   mem_we,
  input logic [DATA_W-1:0]      mem_wdata,
  input logic                   sec_run
);
  logic tsl_go, stop_go, start0_go, start1_go;

  always_comb begin
    tsl_go    = (grant[0] && req_kernel[0] && req_op[0] == OP_TSL) ||
                (grant[1] && req_kernel[1] && req_op[1] == OP_TSL);
    stop_go   = (grant[0] && req_kernel[0] && req_op[0] == OP_STOP) ||
                (grant[1] && req_kernel[1] && req_op[1] == OP_STOP);
    start0_go = grant[0] && req_kernel[0] && req_op[0] == OP_START;
    start1_go = grant[1] && req_op[1] == OP_START;
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R9
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    tsl_go |=> grant == 2'b00); // R8
  AST_LOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tsl_go |=> mem_req && mem_we && mem_wdata == DATA_W'(1)); // R7
  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid != 2'b00 |-> $past(grant) == rsp_valid); // R10
  AST_RUN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_run) |-> $past(start0_go)); // R2
  AST_RUN_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_run) |-> $past(stop_go)); // R5
  AST_RUN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    sec_run && !stop_go |=> sec_run); // R3
  AST_SEC_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    start1_go |=> $stable(sec_run)); // R4
endmodule

bind dcore_ctrl dcc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_op    (req_op),
  .req_kernel(req_kernel),
  .grant     (grant),
  .rsp_valid (rsp_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .sec_run   (sec_run)
);

// File: tb/test_dcore_ctrl.sv
`timescale 1ns/1ps
module test_dcore_ctrl;
  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned TAG_W  = 4;

  typedef struct packed {
    logic [3:0]  rq;
    logic        core;
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [15:0] wdata;
    logic        kern;
    logic [15:0] edata;
    logic        efault;
    logic        erun;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd10, 1'b0, 3'd1, 8'd5, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0}, // R10 write
    '{4'd10, 1'b0, 3'd0, 8'd5, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0}, // R10 read
    '{4'd7,  1'b1, 3'd2, 8'd5, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0}, // R7 tsl old 0
    '{4'd7,  1'b0, 3'd0, 8'd5, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0}, // R7 word now 1
    '{4'd7,  1'b1, 3'd2, 8'd5, 16'h0000, 1'b1, 16'h0001, 1'b0, 1'b0}, // R7 tsl old 1
    '{4'd10, 1'b0, 3'd1, 8'd7, 16'h1234, 1'b1, 16'h0000, 1'b0, 1'b0}, // R10 write
    '{4'd10, 1'b1, 3'd0, 8'd7, 16'h0000, 1'b1, 16'h1234, 1'b0, 1'b0}, // R10 read
    '{4'd4,  1'b1, 3'd3, 8'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0}, // R4 core1 launch
    '{4'd6,  1'b0, 3'd3, 8'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0}, // R6 user launch
    '{4'd2,  1'b0, 3'd3, 8'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b1}, // R2 launch
    '{4'd3,  1'b0, 3'd3, 8'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b1}, // R3 relaunch
    '{4'd6,  1'b1, 3'd4, 8'd0, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b1}, // R6 user stop
    '{4'd5,  1'b1, 3'd4, 8'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0}, // R5 stop
    '{4'd5,  1'b0, 3'd4, 8'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0}, // R5 stop in reset
    '{4'd6,  1'b0, 3'd2, 8'd7, 16'h0000, 1'b0, 16'h0000, 1'b1, 1'b0}, // R6 user tsl
    '{4'd6,  1'b0, 3'd0, 8'd7, 16'h0000, 1'b1, 16'h1234, 1'b0, 1'b0}, // R6 word untouched
    '{4'd6,  1'b0, 3'd6, 8'd0, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0}  // R6 bad opcode
  };

  logic                   clk, rst_n;
  logic [1:0]             req_valid;
  logic [1:0][2:0]        req_op;
  logic [1:0][ADDR_W-1:0] req_addr;
  logic [1:0][DATA_W-1:0] req_wdata;
  logic [1:0][TAG_W-1:0]  req_tag;
  logic [1:0]             req_kernel;
  logic [1:0]             grant, rsp_valid;
  logic [DATA_W-1:0]      rsp_data, mem_wdata, mem_rdata;
  logic [TAG_W-1:0]       rsp_tag;
  logic                   rsp_fault, mem_req, mem_we, sec_run;
  logic [ADDR_W-1:0]      mem_addr, sec_start_pc;
  logic [DATA_W-1:0]      mem [64];

  int n_chk = 0;
  int n_bad = 0;

  dcore_ctrl i_dcore_ctrl (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[5:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[5:0]];
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic issue(input vec_t v, input logic [3:0] tag);
    string rq;
    int waited;
    rq = $sformatf("R%0d", v.rq);
    @(negedge clk);
    req_valid[v.core]  = 1'b1;
    req_op[v.core]     = v.op;
    req_addr[v.core]   = ADDR_W'(v.addr);
    req_wdata[v.core]  = v.wdata;
    req_tag[v.core]    = tag;
    req_kernel[v.core] = v.kern;
    #1;
    waited = 0;
    while (!grant[v.core] && waited < 8) begin
      @(negedge clk); #1; waited++;
    end
    chk(rq, "grant", 32'(grant[v.core]), 32'd1);
    @(negedge clk);
    req_valid[v.core] = 1'b0;
    chk(rq, "rsp_valid", 32'(rsp_valid), v.core ? 32'd2 : 32'd1);
    chk(rq, "rsp_data", 32'(rsp_data), 32'(v.edata));
    chk(rq, "rsp_fault", 32'(rsp_fault), 32'(v.efault));
    chk(rq, "rsp_tag", 32'(rsp_tag), 32'(tag));
    chk(rq, "sec_run", 32'(sec_run), 32'(v.erun));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem_rdata  = '0;
    req_valid  = '0; req_op = '0; req_addr = '0;
    req_wdata  = '0; req_tag = '0; req_kernel = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sec_run in reset", 32'(sec_run), 32'd0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "sec_run", 32'(sec_run), 32'd0);
    chk("R1", "grant", 32'(grant), 32'd0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1", "mem_req", 32'(mem_req), 32'd0);
    chk("R11", "sec_start_pc", 32'(sec_start_pc), 32'd65536);

    // vector table: R2 R3 R4 R5 R6 R7 R10
    for (int i = 0; i < NV; i++) issue(VECS[i], 4'(i));

    // R8 and R9: core1 test-and-set collides with core0 read of same word
    // last grant went to core0, so core1 is preferred now
    @(negedge clk);
    req_valid  = 2'b11;
    req_kernel = 2'b11;
    req_op[0] = 3'd0; req_addr[0] = ADDR_W'(9); req_tag[0] = 4'd1;
    req_op[1] = 3'd2; req_addr[1] = ADDR_W'(9); req_tag[1] = 4'd2;
    #1;
    chk("R9", "collision grant", 32'(grant), 32'd2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1;
    chk("R7", "tsl old value", 32'(rsp_data), 32'd0);
    chk("R7", "tsl rsp core", 32'(rsp_valid), 32'd2);
    chk("R8", "grant during lock", 32'(grant), 32'd0);
    chk("R7", "lock write", 32'({mem_req, mem_we, mem_wdata}), 32'({1'b1, 1'b1, 16'd1}));
    @(negedge clk); #1;
    chk("R9", "waiting core granted", 32'(grant), 32'd1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    chk("R8", "read after lock", 32'(rsp_data), 32'd1);
    chk("R10", "read tag", 32'(rsp_tag), 32'd1);

    // R9: two reads together, core1 preferred after core0's grant, then core0
    @(negedge clk);
    req_valid = 2'b11;
    req_op[0] = 3'd0; req_op[1] = 3'd0;
    #1;
    chk("R9", "rr first", 32'(grant), 32'd2);
    @(negedge clk);
    req_valid[1] = 1'b0;
    #1;
    chk("R9", "rr second", 32'(grant), 32'd1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    #1;
    chk("R9", "idle", 32'(grant), 32'd0);

    // R5: reset mode persists; single requester granted at once (R9)
    chk("R5", "still stopped", 32'(sec_run), 32'd0);
    issue('{4'd9, 1'b1, 3'd0, 8'd7, 16'h0, 1'b1, 16'h1234, 1'b0, 1'b0}, 4'd3);
    finish_run();
  end
endmodule